// File: doc/BRIEF.md
# Redundant-Access Filter with Idle Sleep for a Single-Port SRAM

This wrapper sits between one client and the single-port synchronous SRAM it owns, and it removes memory activity that cannot change any result. It records the location and the returned word of the most recent memory read. A later read of that same location is answered from the memory's output register, and the array is not enabled. It also records the location and the value of the most recent write. A write that repeats both of them is dropped, and the array enable stays low.

When no request has arrived for a programmable number of awake cycles, the wrapper puts the memory to sleep to save leakage. The next request wakes it. That wake costs one cycle, during which `ready` is low, and the client must hold its request until `ready` is high. The memory keeps its array contents while asleep. Unless the output-retaining variant is selected, it does not keep its output register, so the read hold is discarded when the memory goes to sleep.

Three counters report how many reads were skipped, how many writes were skipped and how many cycles the memory spent asleep. They let the savings be measured.

Top module: `sram_access_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, `ready` is 1, `rvalid`, `mem_en` and `mem_sleep` are 0, and all three counters read 0.
- R2: An accepted read of the address whose read hold is valid leaves `mem_en` at 0. One cycle later it returns the held word, and `rd_skips` increments by one.
- R3: An accepted read that misses the hold drives `mem_en` to 1 in its cycle. One cycle later `rdata` carries the word most recently written to that address, or 0 if that address was never written.
- R4: An accepted write whose address and data both equal those of the last write that reached memory leaves `mem_en` at 0 and increments `wr_skips`. Any other accepted write drives `mem_en` to 1 and stores the word.
- R5: Any accepted write to the address of the read hold, whether it is stored or skipped, invalidates the hold. The next read of that address therefore reaches the memory and returns the current word.
- R6: After IDLE_THRESH consecutive awake cycles with `req` low, `mem_sleep` goes to 1 on the following cycle. Any cycle with `req` high restarts the idle count.
- R7: `ready` equals the inverse of `mem_sleep`. A request seen while asleep clears `mem_sleep` at the next edge, so `ready` is low for exactly one cycle and the held request is accepted in the cycle after.
- R8: `mem_en` is 0 in every cycle without an accepted request, and it is never 1 while `mem_sleep` is 1.
- R9: After reset, neither the read hold nor the write record is valid, so the first read and the first write each drive `mem_en` to 1.
- R10: With RETAIN_OUT = 0, entering sleep invalidates the read hold, so the first read after waking reaches the memory.
- R11: `sleep_cycles` increments by one for every clock edge at which `mem_sleep` was 1.
- R12: `rvalid` is 1 exactly in the cycle after each accepted read, whether the read hit the hold or reached the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Client access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Write word |
| ready | output | 1 | Request is accepted this cycle when high |
| rvalid | output | 1 | Read word valid, one cycle after an accepted read |
| rdata | output | DW | Read word |
| mem_en | output | 1 | Memory enable driven to the SRAM model |
| mem_sleep | output | 1 | Sleep signal driven to the SRAM model |
| rd_skips | output | CNT_W | Reads answered from the hold |
| wr_skips | output | CNT_W | Writes dropped as repeats |
| sleep_cycles | output | CNT_W | Cycles spent asleep |

## Verification
`ready` and `mem_en` are combinational results of the current request. The bench drives each request at a falling edge and samples these two outputs 1 ns later, before the rising edge that acts on them. `rvalid`, `rdata`, `mem_sleep` and the three counters change at the rising edge that accepts a request or ends an idle run. The bench samples them at the next falling edge, after it has advanced its own reference model by the same edge. A request made while the memory is asleep is therefore expected to be refused in its own cycle and accepted one cycle later. Read data is expected exactly one edge after acceptance on both the hit path and the miss path.

// File: rtl/sraf_pkg.sv
package sraf_pkg;
  typedef enum logic [0:0] {PWR_AWAKE = 1'b0, PWR_ASLEEP = 1'b1} pwr_state_t;

  function automatic logic same_word(input logic [63:0] a, input logic [63:0] b);
    return a == b;
  endfunction
endpackage

// File: rtl/sraf_sram.sv
module sraf_sram #(
  parameter int AW         = 6,
  parameter int DW         = 16,
  parameter bit RETAIN_OUT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          sleep,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
    end else if (en && we) begin
      arr[addr] <= wdata;
    end
  end

  generate
    if (RETAIN_OUT) begin : g_keep_q
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= '0;
        else if (en && !we)  q <= arr[addr];
      end
    end else begin : g_lose_q
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= '0;
        else if (sleep)      q <= '0;
        else if (en && !we)  q <= arr[addr];
      end
    end
  endgenerate

  AST_EN_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !sleep); // R8
endmodule

// File: rtl/sraf_sleep_ctl.sv
module sraf_sleep_ctl
  import sraf_pkg::*;
#(
  parameter int IDLE_THRESH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic sleep,
  output logic ready,
  output logic sleep_enter
);
  localparam int IW = $clog2(IDLE_THRESH + 1);
  localparam logic [IW-1:0] LAST_IDLE = IW'(IDLE_THRESH - 1);

  pwr_state_t    st;
  logic [IW-1:0] idle_cnt;

  assign sleep       = (st == PWR_ASLEEP);
  assign ready       = (st == PWR_AWAKE);
  assign sleep_enter = !req && (st == PWR_AWAKE) && (idle_cnt == LAST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PWR_AWAKE;
      idle_cnt <= '0;
    end else if (req) begin
      st       <= PWR_AWAKE;
      idle_cnt <= '0;
    end else if (st == PWR_AWAKE) begin
      if (idle_cnt == LAST_IDLE) begin
        st       <= PWR_ASLEEP;
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt < IW'(IDLE_THRESH)); // R6
  AST_WAKE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && req) |=> (!sleep && ready)); // R7
endmodule

// File: rtl/sraf_track.sv
module sraf_track #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic          wr_fire,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          flush,
  output logic          rd_hit,
  output logic          wr_dup
);
  logic          rd_valid, wr_valid;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;

  assign rd_hit = rd_fire && rd_valid && (addr == rd_addr);
  assign wr_dup = wr_fire && wr_valid && (addr == wr_addr) &&
                  sraf_pkg::same_word(64'(wdata), 64'(wr_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
    end else if (rd_fire && !rd_hit) begin
      rd_valid <= 1'b1;
      rd_addr  <= addr;
    end else if ((wr_fire && addr == rd_addr) || flush) begin
      rd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (wr_fire && !wr_dup) begin
      wr_valid <= 1'b1;
      wr_addr  <= addr;
      wr_data  <= wdata;
    end
  end

  AST_WR_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && addr == rd_addr) |=> !rd_valid); // R5
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_valid); // R10
endmodule

// File: rtl/sram_access_filter.sv
module sram_access_filter #(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int IDLE_THRESH = 8,
  parameter bit RETAIN_OUT  = 1'b0,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic             ready,
  output logic             rvalid,
  output logic [DW-1:0]    rdata,
  output logic             mem_en,
  output logic             mem_sleep,
  output logic [CNT_W-1:0] rd_skips,
  output logic [CNT_W-1:0] wr_skips,
  output logic [CNT_W-1:0] sleep_cycles
);
  logic fire, rd_fire, wr_fire, rd_hit, wr_dup, sleep_enter, hold_flush;

  assign fire    = req && ready;
  assign rd_fire = fire && !we;
  assign wr_fire = fire && we;

  sraf_sleep_ctl #(.IDLE_THRESH(IDLE_THRESH)) u_sleep (
    .clk(clk), .rst_n(rst_n), .req(req),
    .sleep(mem_sleep), .ready(ready), .sleep_enter(sleep_enter)
  );

  generate
    if (RETAIN_OUT) begin : g_no_flush
      assign hold_flush = 1'b0;
    end else begin : g_flush
      assign hold_flush = sleep_enter;
    end
  endgenerate

  sraf_track #(.AW(AW), .DW(DW)) u_track (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .wr_fire(wr_fire),
    .addr(addr), .wdata(wdata), .flush(hold_flush),
    .rd_hit(rd_hit), .wr_dup(wr_dup)
  );

  assign mem_en = fire && !rd_hit && !wr_dup;

  sraf_sram #(.AW(AW), .DW(DW), .RETAIN_OUT(RETAIN_OUT)) u_sram (
    .clk(clk), .rst_n(rst_n), .en(mem_en), .we(we), .addr(addr),
    .wdata(wdata), .sleep(mem_sleep), .q(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid       <= 1'b0;
      rd_skips     <= '0;
      wr_skips     <= '0;
      sleep_cycles <= '0;
    end else begin
      rvalid <= rd_fire;
      if (rd_hit)    rd_skips     <= rd_skips + 1'b1;
      if (wr_dup)    wr_skips     <= wr_skips + 1'b1;
      if (mem_sleep) sleep_cycles <= sleep_cycles + 1'b1;
    end
  end

  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit || wr_dup) |-> !mem_en); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !mem_en); // R8
  AST_RD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rvalid); // R12
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> $stable(rdata)); // R2
  AST_SLEEP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sleep |=> (sleep_cycles == $past(sleep_cycles) + CNT_W'(1))); // R11
endmodule

// File: tb/sram_access_filter_test.sv
module sram_access_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int IDLE_THRESH = 8;
  localparam int CNT_W = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, rvalid, mem_en, mem_sleep;
  logic [DW-1:0] rdata;
  logic [CNT_W-1:0] rd_skips, wr_skips, sleep_cycles;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_access_filter #(.AW(AW), .DW(DW), .IDLE_THRESH(IDLE_THRESH),
                       .RETAIN_OUT(1'b0), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rvalid(rvalid), .rdata(rdata), .mem_en(mem_en),
    .mem_sleep(mem_sleep), .rd_skips(rd_skips), .wr_skips(wr_skips),
    .sleep_cycles(sleep_cycles)
  );

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  // reference model
  logic [DW-1:0] m_mem [DEPTH];
  logic m_sleep, m_rdv, m_wrv, m_rvalid;
  logic [AW-1:0] m_rda, m_wra;
  logic [DW-1:0] m_wrd, m_q;
  int m_idle, m_rd_cnt, m_wr_cnt, m_slp_cnt;
  logic s_ready, s_en;

  function automatic logic f_hit(input logic fire, input logic w, input logic [AW-1:0] a);
    return fire && !w && m_rdv && (a == m_rda);
  endfunction

  function automatic logic f_dup(input logic fire, input logic w, input logic [AW-1:0] a,
                                 input logic [DW-1:0] d);
    return fire && w && m_wrv && (a == m_wra) && (d == m_wrd);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_sleep = 0; m_rdv = 0; m_wrv = 0; m_rvalid = 0;
    m_rda = '0; m_wra = '0; m_wrd = '0; m_q = '0;
    m_idle = 0; m_rd_cnt = 0; m_wr_cnt = 0; m_slp_cnt = 0;
  endtask

  // one clock cycle, entered and left at a falling edge
  task automatic step(input logic r, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    logic fire, hit, dup, e_en;
    req = r; we = w; addr = a; wdata = d;
    #1;
    fire = r && !m_sleep;
    hit  = f_hit(fire, w, a);
    dup  = f_dup(fire, w, a, d);
    e_en = fire && !hit && !dup;
    s_ready = ready;
    s_en    = mem_en;
    check("R7 ready", 32'(ready), 32'(!m_sleep));
    if (hit)      check("R2 mem_en on repeat read", 32'(mem_en), 32'(e_en));
    else if (dup) check("R4 mem_en on repeat write", 32'(mem_en), 32'(e_en));
    else          check("R8 mem_en", 32'(mem_en), 32'(e_en));
    @(posedge clk);
    if (m_sleep) m_slp_cnt++;
    m_rvalid = fire && !w;
    if (fire && !w) begin
      if (hit) m_rd_cnt++;
      else begin m_q = m_mem[a]; m_rdv = 1; m_rda = a; end
    end
    if (fire && w) begin
      if (dup) m_wr_cnt++;
      else begin m_mem[a] = d; m_wrv = 1; m_wra = a; m_wrd = d; end
      if (m_rdv && a == m_rda) m_rdv = 0;
    end
    if (r) begin
      m_idle = 0; m_sleep = 0;
    end else if (!m_sleep) begin
      if (m_idle == IDLE_THRESH - 1) begin m_sleep = 1; m_idle = 0; m_rdv = 0; end
      else m_idle++;
    end
    @(negedge clk);
    check("R6 mem_sleep", 32'(mem_sleep), 32'(m_sleep));
    check("R12 rvalid", 32'(rvalid), 32'(m_rvalid));
    if (m_rvalid) begin
      if (hit) check("R2 held rdata", 32'(rdata), 32'(m_q));
      else     check("R3 rdata", 32'(rdata), 32'(m_q));
    end
    check("R2 rd_skips", 32'(rd_skips), 32'(m_rd_cnt));
    check("R4 wr_skips", 32'(wr_skips), 32'(m_wr_cnt));
    check("R11 sleep_cycles", 32'(sleep_cycles), 32'(m_slp_cnt));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    check("R1 ready in reset", 32'(ready), 32'd1);
    check("R1 mem_sleep in reset", 32'(mem_sleep), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rvalid", 32'(rvalid), 32'd0);
    check("R1 mem_en", 32'(mem_en), 32'd0);
    check("R1 mem_sleep", 32'(mem_sleep), 32'd0);
    check("R1 counters", 32'(rd_skips) | 32'(wr_skips) | 32'(sleep_cycles), 32'd0);

    step(1, 1, 6'd5, 16'h1111);
    check("R9 first write reaches memory", 32'(s_en), 32'd1);
    step(1, 0, 6'd5, '0);
    check("R9 first read reaches memory", 32'(s_en), 32'd1);
    step(1, 0, 6'd5, '0);
    check("R2 repeat read kept off memory", 32'(s_en), 32'd0);
    step(1, 1, 6'd5, 16'h1111);
    check("R4 repeat write kept off memory", 32'(s_en), 32'd0);
    step(1, 0, 6'd5, '0);
    check("R5 read after write to held address", 32'(s_en), 32'd1);
    step(1, 1, 6'd5, 16'h2222);
    step(1, 0, 6'd5, '0);
    check("R5 fresh word returned", 32'(rdata), 32'h2222);
    for (int i = 0; i < IDLE_THRESH - 1; i++) step(0, 0, '0, '0);
    check("R6 still awake one cycle early", 32'(mem_sleep), 32'd0);
    step(0, 0, '0, '0);
    check("R6 asleep after idle run", 32'(mem_sleep), 32'd1);
    repeat (3) step(0, 0, '0, '0);
    step(1, 0, 6'd5, '0);
    check("R7 refused while waking", 32'(s_ready), 32'd0);
    step(1, 0, 6'd5, '0);
    check("R7 accepted after wake", 32'(s_ready), 32'd1);
    check("R10 hold dropped by sleep", 32'(s_en), 32'd1);
    check("R3 word after wake", 32'(rdata), 32'h2222);

    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 60 == 0) begin
        for (int k = 0; k < IDLE_THRESH + 3; k++) step(0, 0, '0, '0);
      end else begin
        step(($urandom % 4) != 0, $urandom % 2, AW'($urandom % 4), DW'($urandom % 3));
      end
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule